// File: doc/BRIEF.md
# Exception Entry Sequencer

This block is the multi-cycle controller that a 16-bit-bus processor core hands control to when an exception must be entered. It accepts three kinds of request: reset, an autovectored interrupt at a level from 1 to 7, and a trap or internal fault that carries a vector number formed inside the core. On acceptance it captures the status register, program counter and supervisor stack pointer presented by the core. It builds the new status register, which forces supervisor mode and clears tracing, and forms the vector number internally. A non-reset exception then pushes a three-word frame onto the supervisor stack. Last, the block reads the 32-bit handler address from the vector table.

All memory traffic goes over one word-wide request/acknowledge port. Each access holds its request until the acknowledge arrives. When the sequence ends, the block hands the new status register, stack pointer and program counter back to the core with a one-cycle completion pulse. Reset takes a shortened path. It takes no copy of the status register and writes nothing. It loads the stack pointer from table address 0 and the program counter from address 4. A reset request arriving mid-sequence abandons the current entry and restarts.

Top module: `exc_entry_seq`

## Requirements
- R1: `busy` is high from the cycle after a request is accepted until the cycle in which the new program counter is delivered. In that cycle `done` is high for exactly one cycle, `busy` is low, and `sr_out`, `ssp_out` and `pc_out` hold the results.
- R2: In the delivered status register, bit 13 (supervisor) is 1 and bit 15 (trace) is 0. For non-reset exceptions all bits other than 15, 13 and the mask field are copied from the `sr_in` captured at acceptance.
- R3: The mask field, bits 10..8, is loaded with the level for an interrupt and with 7 for reset. A trap leaves the mask as captured.
- R4: An interrupt at level n uses vector 24+n, and a trap uses `trap_vec`. The handler address is read as two words: the high word at byte address vector*4, then the low word at vector*4+2. `pc_out` is {high, low}.
- R5: A non-reset exception performs three writes, each predecrementing the stack pointer by 2. The first writes the PC low word to ssp_in-2. The second writes the PC high word to ssp_in-4. The third writes the captured status register, unmodified, to ssp_in-6. `ssp_out` is ssp_in-6.
- R6: A reset exception performs no write. It reads byte addresses 0, 2, 4 and 6 in that order. `ssp_out` is {word@0, word@2}, `pc_out` is {word@4, word@6}, and `sr_out` is 16'h2700.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged. The sequencer advances only on a cycle with `mem_ack` high.
- R8: Interrupt and trap requests that arrive while `busy` is high are ignored. A reset request while busy abandons the current sequence in that same cycle, even on an acknowledge cycle, and starts the reset path.
- R9: From idle, reset takes precedence over trap, and trap over interrupt. An interrupt request at level 0 is ignored.
- R10: While `rst_n` is low at a clock edge, the block returns to idle with `busy`, `done` and `mem_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_irq | input | 1 | Interrupt request |
| irq_level | input | 3 | Interrupt level, 1..7 |
| req_trap | input | 1 | Trap or internal-fault request |
| trap_vec | input | 8 | Vector number of the trap or fault |
| sr_in | input | 16 | Current status register |
| pc_in | input | 32 | Program counter to be stacked |
| ssp_in | input | 32 | Current supervisor stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a stack write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the word access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes on this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sr_out | output | 16 | New status register |
| ssp_out | output | 32 | New supervisor stack pointer |
| pc_out | output | 32 | New program counter |

## Verification
A reset request and a memory acknowledge for a stack write can land on the same clock edge. The design must then drop the half-built frame and start the reset path, not count the write and go on pushing. The bench's memory model raises `req_reset` on the very edge that acknowledges the second frame write. It then judges the outcome from the port traffic: exactly two writes in total, reads at 0, 2, 4 and 6, and the reset-path values on the outputs. A second overlap is also checked. New interrupt and trap requests are raised during a busy sequence, and the bench confirms from the access counts and the delivered program counter that they left no trace.

// File: rtl/exc_pkg.sv
// Package: shared kinds, states and status-register layout for the
// exception entry sequencer. Assumes a 16-bit status register.
package exc_pkg;

    localparam int SR_W          = 16;
    localparam int SR_T_BIT      = 15;
    localparam int SR_S_BIT      = 13;
    localparam int SR_MASK_LSB   = 8;
    localparam int SR_MASK_W     = 3;
    localparam int VEC_W         = 8;
    localparam int AUTOVEC_BASE  = 24;
    localparam int RESET_PC_VEC  = 1;
    localparam logic [SR_W-1:0] RESET_SR =
        SR_W'((1 << SR_S_BIT) | (7 << SR_MASK_LSB));

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_RESET = 2'd1,
        K_IRQ   = 2'd2,
        K_TRAP  = 2'd3
    } exc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SSP   = 2'd1,
        ST_PUSH  = 2'd2,
        ST_FETCH = 2'd3
    } seq_state_t;

endpackage

// File: rtl/exc_vector_gen.sv
// Vector number former. Interrupts are autovectored from their level,
// traps carry their own number, and reset selects the PC vector (the
// stack pointer vector at 0 is handled by the sequencer's reset path).
// Assumes kind K_IRQ is only presented with a nonzero level.
module exc_vector_gen
    import exc_pkg::*;
(
    input  exc_kind_t        kind,
    input  logic [2:0]       irq_level,
    input  logic [VEC_W-1:0] trap_vec,
    output logic [VEC_W-1:0] vec_num
);

    // Select the vector source by exception kind.
    always_comb begin
        case (kind)
            K_IRQ:   vec_num = VEC_W'(AUTOVEC_BASE) + VEC_W'(irq_level);
            K_TRAP:  vec_num = trap_vec;
            K_RESET: vec_num = VEC_W'(RESET_PC_VEC);
            default: vec_num = '0;
        endcase
    end

endmodule

// File: rtl/exc_sr_update.sv
// Status register rewrite at exception entry: supervisor on, trace off,
// mask loaded for interrupts (with the level) and reset (with 7).
// Reset ignores the incoming status register entirely.
module exc_sr_update
    import exc_pkg::*;
(
    input  exc_kind_t       kind,
    input  logic [SR_W-1:0] sr_in,
    input  logic [2:0]      irq_level,
    output logic [SR_W-1:0] sr_new
);

    // Build the handler's status register from the captured one.
    always_comb begin
        sr_new           = sr_in;
        sr_new[SR_S_BIT] = 1'b1;
        sr_new[SR_T_BIT] = 1'b0;
        case (kind)
            K_RESET: sr_new = RESET_SR;
            K_IRQ:   sr_new[SR_MASK_LSB +: SR_MASK_W] = irq_level;
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_seq_fsm.sv
// Sequencing core: captures the entry context on start, then runs the
// memory accesses one word at a time on a request/acknowledge port:
// reset loads SSP (addresses 0,2); other kinds push PC low, PC high and
// SR with predecrement; all finish by reading the vector (high, low).
// Assumes ADDR_W >= 11 and ADDR_W <= 2*DATA_W; start may arrive at any
// time and always wins over an acknowledge in the same cycle.
module exc_seq_fsm
    import exc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_reset,
    input  logic [VEC_W-1:0]    vec_num,
    input  logic [DATA_W-1:0]   sr_snap,
    input  logic [DATA_W-1:0]   sr_new,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [2*DATA_W-1:0] ssp_in,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ack,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   sr_out,
    output logic [2*DATA_W-1:0] ssp_out,
    output logic [2*DATA_W-1:0] pc_out
);

    localparam int LONG_W    = 2 * DATA_W;
    localparam int PAD_VEC_W = ADDR_W - VEC_W - 2;
    localparam int PAD_LOW_W = ADDR_W - 2;
    localparam int PUSH_LAST = 2;

    seq_state_t          state_q;
    logic [1:0]          widx_q;
    logic [VEC_W-1:0]    vec_q;
    logic [DATA_W-1:0]   snap_q;
    logic [DATA_W-1:0]   sr_q;
    logic [LONG_W-1:0]   ssp_q;
    logic [LONG_W-1:0]   pc_save_q;
    logic [LONG_W-1:0]   pc_q;
    logic [DATA_W-1:0]   hi_q;
    logic                rst_path_q;
    logic                busy_q;
    logic                done_q;

    // State, word counter and context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            widx_q     <= '0;
            vec_q      <= '0;
            snap_q     <= '0;
            sr_q       <= '0;
            ssp_q      <= '0;
            pc_save_q  <= '0;
            pc_q       <= '0;
            hi_q       <= '0;
            rst_path_q <= 1'b0;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rst_path_q <= start_reset;
                vec_q      <= vec_num;
                snap_q     <= start_reset ? snap_q : sr_snap;
                sr_q       <= sr_new;
                ssp_q      <= ssp_in;
                pc_save_q  <= pc_in;
                widx_q     <= '0;
                busy_q     <= 1'b1;
                state_q    <= start_reset ? ST_SSP : ST_PUSH;
            end else if (mem_ack) begin
                case (state_q)
                    ST_SSP: begin
                        if (widx_q == 2'd0) begin
                            hi_q   <= mem_rdata;
                            widx_q <= 2'd1;
                        end else begin
                            ssp_q   <= {hi_q, mem_rdata};
                            widx_q  <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                    ST_PUSH: begin
                        ssp_q <= ssp_q - LONG_W'(2);
                        if (widx_q == 2'(PUSH_LAST)) begin
                            widx_q  <= '0;
                            state_q <= ST_FETCH;
                        end else begin
                            widx_q <= widx_q + 2'd1;
                        end
                    end
                    ST_FETCH: begin
                        if (widx_q == 2'd0) begin
                            hi_q   <= mem_rdata;
                            widx_q <= 2'd1;
                        end else begin
                            pc_q    <= {hi_q, mem_rdata};
                            widx_q  <= '0;
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Memory port drive: address and data for the current word.
    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_PUSH);
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_SSP:   mem_addr = {{PAD_LOW_W{1'b0}}, widx_q[0], 1'b0};
            ST_PUSH:  mem_addr = ADDR_W'(ssp_q - LONG_W'(2));
            ST_FETCH: mem_addr = {{PAD_VEC_W{1'b0}}, vec_q, widx_q[0], 1'b0};
            default:  ;
        endcase
        if (state_q == ST_PUSH) begin
            case (widx_q)
                2'd0:    mem_wdata = pc_save_q[DATA_W-1:0];
                2'd1:    mem_wdata = pc_save_q[LONG_W-1:DATA_W];
                default: mem_wdata = snap_q;
            endcase
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign sr_out  = sr_q;
    assign ssp_out = ssp_q;
    assign pc_out  = pc_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !start) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req)); // R1
    AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_path_q && busy) |-> !mem_we); // R6

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top. Decodes which request is accepted
// (reset at any time, otherwise trap before interrupt when idle; level 0
// interrupts are not requests), forms the vector and new status register,
// and hands them to the sequencing core. Assumes requests are levels held
// by the core; the ones seen while busy are dropped, not queued.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_reset,
    input  logic                req_irq,
    input  logic [2:0]          irq_level,
    input  logic                req_trap,
    input  logic [7:0]          trap_vec,
    input  logic [15:0]         sr_in,
    input  logic [31:0]         pc_in,
    input  logic [31:0]         ssp_in,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [15:0]         mem_wdata,
    input  logic [15:0]         mem_rdata,
    input  logic                mem_ack,
    output logic                busy,
    output logic                done,
    output logic [15:0]         sr_out,
    output logic [31:0]         ssp_out,
    output logic [31:0]         pc_out
);

    exc_kind_t        kind;
    logic             start;
    logic [VEC_W-1:0] vec_num;
    logic [SR_W-1:0]  sr_new;

    // Acceptance decode with fixed precedence.
    always_comb begin
        if (req_reset)
            kind = K_RESET;
        else if (busy)
            kind = K_NONE;
        else if (req_trap)
            kind = K_TRAP;
        else if (req_irq && (irq_level != 3'd0))
            kind = K_IRQ;
        else
            kind = K_NONE;
        start = (kind != K_NONE);
    end

    exc_vector_gen u_vec (
        .kind      (kind),
        .irq_level (irq_level),
        .trap_vec  (trap_vec),
        .vec_num   (vec_num)
    );

    exc_sr_update u_sr (
        .kind      (kind),
        .sr_in     (sr_in),
        .irq_level (irq_level),
        .sr_new    (sr_new)
    );

    exc_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_reset (kind == K_RESET),
        .vec_num     (vec_num),
        .sr_snap     (sr_in),
        .sr_new      (sr_new),
        .pc_in       (pc_in),
        .ssp_in      (ssp_in),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .busy        (busy),
        .done        (done),
        .sr_out      (sr_out),
        .ssp_out     (ssp_out),
        .pc_out      (pc_out)
    );

    AST_SR_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sr_out[SR_S_BIT] && !sr_out[SR_T_BIT])); // R2
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R1

endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_reset = 1'b0, req_irq = 1'b0, req_trap = 1'b0;
    logic [2:0]  irq_level = '0;
    logic [7:0]  trap_vec = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] pc_in = '0, ssp_in = '0;
    logic mem_req, mem_we, busy, done;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, sr_out;
    logic [15:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic [31:0] ssp_out, pc_out;

    int n_chk = 0, n_fail = 0;
    logic [15:0] mem [0:1023];
    int lat = 0, wait_cnt = 0, wr_n = 0, rd_n = 0, inject_at = -1;
    bit inj_fired = 0, pending = 0;
    logic [AW-1:0] cap_addr;
    logic cap_we;
    logic [15:0] cap_wdata;
    logic [AW-1:0] wr_addr [0:15];
    logic [15:0]   wr_data [0:15];
    logic [AW-1:0] rd_addr [0:15];

    exc_entry_seq #(.ADDR_W(AW), .DATA_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_irq(req_irq),
        .irq_level(irq_level), .req_trap(req_trap), .trap_vec(trap_vec),
        .sr_in(sr_in), .pc_in(pc_in), .ssp_in(ssp_in), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
        .sr_out(sr_out), .ssp_out(ssp_out), .pc_out(pc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Memory model: acknowledges after lat waiting cycles, logs traffic,
    // optionally raises req_reset on the edge that acks write inject_at.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            if (inj_fired) begin req_reset = 1'b0; inj_fired = 0; end
        end else if (mem_req && rst_n) begin
            if (!pending) begin
                pending = 1; wait_cnt = 0;
                cap_addr = mem_addr; cap_we = mem_we; cap_wdata = mem_wdata;
            end
            if (wait_cnt >= lat) begin
                chk("R7", "access held until ack",
                    32'((mem_addr == cap_addr) && (mem_we == cap_we) &&
                        (!mem_we || mem_wdata == cap_wdata)), 32'd1);
                pending = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[10:1]] = mem_wdata;
                    if (wr_n < 16) begin wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; end
                    wr_n++;
                    if (wr_n == inject_at) begin req_reset = 1'b1; inj_fired = 1; end
                end else begin
                    mem_rdata = mem[mem_addr[10:1]];
                    if (rd_n < 16) rd_addr[rd_n] = mem_addr;
                    rd_n++;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    task automatic issue(input bit r, input bit i, input bit t,
                         input logic [2:0] lv, input logic [7:0] tv);
        @(negedge clk);
        wr_n = 0; rd_n = 0; pending = 0;
        req_reset = r; req_irq = i; req_trap = t; irq_level = lv; trap_vec = tv;
        @(negedge clk);
        req_reset = 1'b0; req_irq = 1'b0; req_trap = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        bit bad = 0;
        while (!done && n < 400) begin
            if (!busy) bad = 1;
            @(negedge clk); n++;
        end
        chk(tag, "busy until done (R1)", 32'(bad), 32'd0);
        chk(tag, "done seen (R1)", 32'(done), 32'd1);
        chk(tag, "busy low with done (R1)", 32'(busy), 32'd0);
        @(negedge clk);
        chk(tag, "done one cycle (R1)", 32'(done), 32'd0);
    endtask

    function automatic logic [15:0] exp_sr(input logic [15:0] s, input bit irq,
                                           input logic [2:0] lv);
        logic [15:0] e = s;
        e[13] = 1'b1; e[15] = 1'b0;
        if (irq) e[10:8] = lv;
        return e;
    endfunction

    task automatic check_frame(input string tag, input logic [15:0] s,
                               input logic [31:0] pc, input logic [31:0] sp);
        chk(tag, "write count (R5)", 32'(wr_n), 32'd3);
        chk(tag, "w0 addr (R5)", 32'(wr_addr[0]), sp - 2);
        chk(tag, "w0 pc low (R5)", 32'(wr_data[0]), 32'(pc[15:0]));
        chk(tag, "w1 addr (R5)", 32'(wr_addr[1]), sp - 4);
        chk(tag, "w1 pc high (R5)", 32'(wr_data[1]), 32'(pc[31:16]));
        chk(tag, "w2 addr (R5)", 32'(wr_addr[2]), sp - 6);
        chk(tag, "w2 saved sr (R5)", 32'(wr_data[2]), 32'(s));
        chk(tag, "ssp_out (R5)", ssp_out, sp - 6);
    endtask

    task automatic t_reset_state;
        chk("R10", "busy after reset", 32'(busy), 0);
        chk("R10", "done after reset", 32'(done), 0);
        chk("R10", "mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic t_reset_exc;
        lat = 1; sr_in = 16'hA71F;
        issue(1, 0, 0, 3'd0, 8'd0);
        wait_done("R6");
        chk("R6", "no writes", 32'(wr_n), 0);
        chk("R6", "read count", 32'(rd_n), 4);
        for (int k = 0; k < 4; k++) chk("R6", "read order", 32'(rd_addr[k]), 32'(2*k));
        chk("R6", "ssp from 0", ssp_out, 32'h0000_0700);
        chk("R6", "pc from 4", pc_out, 32'h0000_0200);
        chk("R3", "reset sr mask 7", 32'(sr_out), 32'h2700);
    endtask

    task automatic t_irq(input logic [2:0] lv, input int l, input logic [15:0] s);
        int v = 24 + lv;
        lat = l; sr_in = s; pc_in = 32'h0001_2344 + lv; ssp_in = 32'h700;
        mem[v*2] = 16'h0003; mem[v*2+1] = 16'h1000 + 16'(lv);
        issue(0, 1, 0, lv, 8'd0);
        wait_done("R4");
        check_frame("R5", s, 32'h0001_2344 + lv, 32'h700);
        chk("R4", "vec hi addr", 32'(rd_addr[0]), 32'(v*4));
        chk("R4", "vec lo addr", 32'(rd_addr[1]), 32'(v*4 + 2));
        chk("R4", "irq pc", pc_out, {16'h0003, 16'h1000 + 16'(lv)});
        chk("R3", "irq sr mask", 32'(sr_out), 32'(exp_sr(s, 1, lv)));
        chk("R2", "irq sr S/T", 32'(sr_out[15:13]), 32'b001);
    endtask

    task automatic t_trap(input logic [7:0] tv, input int l, input logic [15:0] s);
        lat = l; sr_in = s; pc_in = 32'hCAFE_0010; ssp_in = 32'h6F0;
        mem[tv*2] = 16'h0001; mem[tv*2+1] = 16'h0ABC;
        issue(0, 0, 1, 3'd0, tv);
        wait_done("R4");
        check_frame("R5", s, 32'hCAFE_0010, 32'h6F0);
        chk("R4", "trap vec addr", 32'(rd_addr[0]), 32'(tv) * 4);
        chk("R4", "trap pc", pc_out, 32'h0001_0ABC);
        chk("R3", "trap mask kept", 32'(sr_out[10:8]), 32'(s[10:8]));
        chk("R2", "trap sr", 32'(sr_out), 32'(exp_sr(s, 0, 3'd0)));
    endtask

    task automatic t_busy_ignore;
        lat = 3; sr_in = 16'h0000; pc_in = 32'h10; ssp_in = 32'h700;
        mem[10] = 16'h0001; mem[11] = 16'h0ABC;
        issue(0, 0, 1, 3'd0, 8'd5);
        @(negedge clk); @(negedge clk);
        req_irq = 1; irq_level = 3'd6; req_trap = 1; trap_vec = 8'd9;
        @(negedge clk);
        req_irq = 0; req_trap = 0;
        wait_done("R8");
        chk("R8", "writes while busy", 32'(wr_n), 3);
        chk("R8", "reads while busy", 32'(rd_n), 2);
        chk("R8", "pc from first trap", pc_out, 32'h0001_0ABC);
        repeat (5) @(negedge clk);
        chk("R8", "no late start", 32'(busy), 0);
        chk("R8", "no late access", 32'(rd_n + wr_n), 5);
    endtask

    task automatic t_level0;
        issue(0, 1, 0, 3'd0, 8'd0);
        chk("R9", "level 0 busy", 32'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R9", "level 0 no access", 32'(mem_req), 0);
    endtask

    task automatic t_priority;
        lat = 0; sr_in = 16'h0300; pc_in = 32'h20; ssp_in = 32'h700;
        mem[10] = 16'h0001; mem[11] = 16'h0ABC;
        issue(0, 1, 1, 3'd4, 8'd5);
        wait_done("R9");
        chk("R9", "trap over irq addr", 32'(rd_addr[0]), 32'd20);
        chk("R9", "trap over irq mask", 32'(sr_out[10:8]), 32'd3);
        issue(1, 0, 1, 3'd0, 8'd5);
        wait_done("R9");
        chk("R9", "reset over trap writes", 32'(wr_n), 0);
        chk("R9", "reset over trap pc", pc_out, 32'h0000_0200);
    endtask

    task automatic t_restart;
        lat = 0; sr_in = 16'h0000; pc_in = 32'h30; ssp_in = 32'h700;
        inject_at = 2;
        issue(0, 0, 1, 3'd0, 8'd5);
        wait_done("R8");
        inject_at = -1;
        chk("R8", "writes before restart", 32'(wr_n), 2);
        chk("R8", "restart reads", 32'(rd_n), 4);
        chk("R8", "restart first read", 32'(rd_addr[0]), 0);
        chk("R8", "restart ssp", ssp_out, 32'h0000_0700);
        chk("R8", "restart sr", 32'(sr_out), 32'h2700);
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = 16'h0;
        mem[0] = 16'h0000; mem[1] = 16'h0700;
        mem[2] = 16'h0000; mem[3] = 16'h0200;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_exc();
        t_irq(3'd3, 2, 16'h8012);
        t_irq(3'd1, 0, 16'h0700);
        t_irq(3'd7, 1, 16'hA0FF);
        t_trap(8'd5, 0, 16'h8504);
        t_trap(8'd64, 2, 16'h0304);
        t_busy_ignore();
        t_level0();
        t_priority();
        t_restart();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        t_reset_state();
        summary();
    end

endmodule